// File: doc/BRIEF.md
# Autoranging Oversampling Front-End Controller

This block sits between a 16-bit SAR converter and the data path that consumes its samples. The converter is fed by an amplifier with two gain settings, unity and one hundred. The block picks the gain from the incoming codes. When a high-gain sample climbs past an upper threshold, it drops the gain immediately, so the converter is not driven into clipping. It raises the gain again only after a run of quiet samples below a lower threshold.

Every accepted sample is brought to one common scale: a unity-gain code is multiplied by one hundred, and a high-gain code is used unchanged. The amplifier needs time to settle after any gain change, so a programmable number of samples after each change is replaced by the last trustworthy scaled value. The scaled samples are summed in blocks of 72. Each block gives one wide result at the decimated rate, with a flag that marks blocks containing unity-gain samples.

The four settings are loaded through a small write port and come out of reset with usable defaults. Those defaults are an upper threshold near two thirds of full scale, a lower threshold of 180 codes, a hold of one block and a settle mask of four samples. A sticky flag records any sample at either full-scale code.

Top module: `autorange_osr_ctrl`

## Requirements
- R1: After reset the gain output is low (unity gain), no result strobe is given, the overrange flag is clear, the block counter starts at zero, and the configuration is upper threshold 21845, lower threshold 180, hold 72 and settle 4.
- R2: While the gain is high, an accepted sample whose magnitude is strictly above the upper threshold makes the gain output low from the next clock edge on. A magnitude equal to the threshold leaves the gain high.
- R3: While the gain is low, the gain output goes high after the hold count of consecutive unmasked samples whose magnitude is strictly below the lower threshold. A hold count of 0 acts as 1. An unmasked sample at or above the lower threshold restarts the run.
- R4: After any gain change, the next settle-count accepted samples are masked. Each one contributes the last unmasked scaled sample (0 after reset) in place of its own value. Masked samples still count toward the block, can still force the gain down, and do not count toward the up-switch run.
- R5: An unmasked sample taken at unity gain is scaled by 100, and one taken at high gain is used unchanged. The gain a sample was taken at is the gain output level in the cycle it is accepted.
- R6: Every 72 accepted samples, res_valid pulses for one cycle, in the cycle after the 72nd sample is accepted. res_sum then holds the signed sum of the 72 scaled samples. Cycles without smp_valid do not advance the block.
- R7: res_lowgain is 1 if any sample of the reported block was taken at unity gain, and 0 otherwise.
- R8: A sample with code 0x7FFF or 0x8000 sets ovr_flag from the next edge. The flag stays set until ovr_clr is asserted with no such sample in the same cycle, and a new full-scale sample wins over a clear.
- R9: A write with cfg_we high loads cfg_wdata into the setting chosen by cfg_addr: 0 upper threshold, 1 lower threshold, 2 hold count, 3 settle count. The new value applies from the next sample on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | A converter sample is present this cycle |
| smp_data | input | 16 | Signed two's-complement converter code |
| cfg_we | input | 1 | Setting write enable |
| cfg_addr | input | 2 | Setting select (0 upper, 1 lower, 2 hold, 3 settle) |
| cfg_wdata | input | 16 | Setting write value |
| ovr_clr | input | 1 | Clears the overrange flag |
| gain_hi | output | 1 | Amplifier select, 1 = gain 100, 0 = gain 1 |
| res_valid | output | 1 | One-cycle strobe for a finished block |
| res_sum | output | 31 | Signed block sum on the x100 scale |
| res_lowgain | output | 1 | Block holds at least one unity-gain sample |
| ovr_flag | output | 1 | Sticky full-scale indicator |

## Verification
Two events can fall on the same sample: the gain drop and the end of a block. The bench arranges this by filling a block at high gain and then sending, as its 72nd sample, a code above the upper threshold. The result for that block must still carry the sample unscaled with the unity-gain flag clear, and the flag must first appear in the following block. A second case sends a full-scale code in the same cycle as a clear request, and the overrange flag must stay set.

// File: rtl/autorange_osr_ctrl.sv
module autorange_osr_ctrl #(
  parameter int SMP_W = 16,
  parameter int DECIM = 72,
  parameter int ACC_W = 31,
  parameter int CFG_W = 16,
  parameter logic [CFG_W-1:0] DEF_THR_HI = 16'd21845,
  parameter logic [CFG_W-1:0] DEF_THR_LO = 16'd180,
  parameter logic [CFG_W-1:0] DEF_HOLD   = 16'd72,
  parameter logic [CFG_W-1:0] DEF_SETTLE = 16'd4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_valid,
  input  logic signed [SMP_W-1:0] smp_data,
  input  logic                    cfg_we,
  input  logic [1:0]              cfg_addr,
  input  logic [CFG_W-1:0]        cfg_wdata,
  input  logic                    ovr_clr,
  output logic                    gain_hi,
  output logic                    res_valid,
  output logic signed [ACC_W-1:0] res_sum,
  output logic                    res_lowgain,
  output logic                    ovr_flag
);
  localparam int NORM_W = SMP_W + 8;
  localparam int CNT_W  = $clog2(DECIM);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DECIM - 1);

  logic [CFG_W-1:0] thr_hi, thr_lo, hold_len, settle_len;
  logic [CFG_W-1:0] below_cnt, mask_cnt;
  logic [CNT_W-1:0] blk_cnt;
  logic signed [ACC_W-1:0]  acc;
  logic signed [NORM_W-1:0] last_norm;
  logic blk_low;

  logic [SMP_W:0] mag;
  logic masked, full_scale, go_down, go_up, quiet;
  logic signed [NORM_W-1:0] ext, x100, norm;
  logic signed [ACC_W-1:0]  acc_next;
  logic [CFG_W-1:0] hold_eff;

  assign mag        = smp_data[SMP_W-1] ? (SMP_W+1)'(-$signed({smp_data[SMP_W-1], smp_data}))
                                        : {1'b0, smp_data};
  assign masked     = (mask_cnt != '0);
  assign full_scale = (smp_data == {1'b0, {(SMP_W-1){1'b1}}}) || (smp_data == {1'b1, {(SMP_W-1){1'b0}}});
  assign ext        = NORM_W'(smp_data);
  assign x100       = (ext <<< 6) + (ext <<< 5) + (ext <<< 2);
  assign norm       = masked ? last_norm : (gain_hi ? ext : x100);
  assign acc_next   = ((blk_cnt == '0) ? '0 : acc) + ACC_W'(norm);
  assign hold_eff   = (hold_len == '0) ? CFG_W'(1) : hold_len;
  assign quiet      = (mag < {1'b0, thr_lo});
  assign go_down    = smp_valid && gain_hi && (mag > {1'b0, thr_hi});
  assign go_up      = smp_valid && !gain_hi && !masked && quiet && (below_cnt + 1'b1 >= hold_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_hi     <= DEF_THR_HI;
      thr_lo     <= DEF_THR_LO;
      hold_len   <= DEF_HOLD;
      settle_len <= DEF_SETTLE;
    end else if (cfg_we) begin
      case (cfg_addr)
        2'd0: thr_hi     <= cfg_wdata;
        2'd1: thr_lo     <= cfg_wdata;
        2'd2: hold_len   <= cfg_wdata;
        default: settle_len <= cfg_wdata;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_hi   <= 1'b0;
      below_cnt <= '0;
      mask_cnt  <= '0;
    end else if (smp_valid) begin
      if (go_down || go_up) begin
        gain_hi   <= go_up;
        below_cnt <= '0;
        mask_cnt  <= settle_len;
      end else begin
        if (masked) mask_cnt <= mask_cnt - 1'b1;
        if (!gain_hi && !masked) below_cnt <= quiet ? below_cnt + 1'b1 : '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_cnt     <= '0;
      acc         <= '0;
      blk_low     <= 1'b0;
      last_norm   <= '0;
      res_valid   <= 1'b0;
      res_sum     <= '0;
      res_lowgain <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      if (smp_valid) begin
        if (!masked) last_norm <= norm;
        acc     <= acc_next;
        blk_low <= ((blk_cnt == '0) ? 1'b0 : blk_low) | !gain_hi;
        if (blk_cnt == LAST) begin
          blk_cnt     <= '0;
          res_valid   <= 1'b1;
          res_sum     <= acc_next;
          res_lowgain <= ((blk_cnt == '0) ? 1'b0 : blk_low) | !gain_hi;
        end else begin
          blk_cnt <= blk_cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       ovr_flag <= 1'b0;
    else if (smp_valid && full_scale) ovr_flag <= 1'b1;
    else if (ovr_clr)                 ovr_flag <= 1'b0;
  end
endmodule

// File: rtl/autorange_osr_ctrl_chk.sv
module autorange_osr_ctrl_chk #(
  parameter int SMP_W = 16,
  parameter int CFG_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             smp_valid,
  input logic [SMP_W-1:0] smp_data,
  input logic             ovr_clr,
  input logic             gain_hi,
  input logic             res_valid,
  input logic             ovr_flag,
  input logic [SMP_W:0]   mag,
  input logic [CFG_W-1:0] thr_hi
);
  // R2
  fast_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && gain_hi && (mag > {1'b0, thr_hi})) |=> !gain_hi);

  // R3
  rise_needs_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gain_hi) |-> $past(smp_valid));

  // R6
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R6
  strobe_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(smp_valid));

  // R8
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && (smp_data == 16'h7FFF || smp_data == 16'h8000)) |=> ovr_flag);

  // R8
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !ovr_clr) |=> ovr_flag);
endmodule

bind autorange_osr_ctrl autorange_osr_ctrl_chk #(.SMP_W(SMP_W), .CFG_W(CFG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
  .ovr_clr(ovr_clr), .gain_hi(gain_hi), .res_valid(res_valid),
  .ovr_flag(ovr_flag), .mag(mag), .thr_hi(thr_hi)
);

// File: tb/test_autorange_osr_ctrl.sv
module test_autorange_osr_ctrl;
  logic clk = 0, rst_n = 0;
  logic smp_valid = 0, cfg_we = 0, ovr_clr = 0;
  logic signed [15:0] smp_data = 0;
  logic [1:0]  cfg_addr = 0;
  logic [15:0] cfg_wdata = 0;
  logic gain_hi, res_valid, res_lowgain, ovr_flag;
  logic signed [30:0] res_sum;

  always #10 clk = ~clk;

  autorange_osr_ctrl i_autorange_osr_ctrl (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .ovr_clr(ovr_clr),
    .gain_hi(gain_hi), .res_valid(res_valid), .res_sum(res_sum),
    .res_lowgain(res_lowgain), .ovr_flag(ovr_flag));

  int checks = 0, errors = 0;
  bit done = 0;
  int exp_sum_q[$];
  bit exp_low_q[$];

  int m_thr_hi = 21845, m_thr_lo = 180, m_hold = 72, m_settle = 4;
  int m_gain = 0, m_mask = 0, m_below = 0, m_last = 0, m_cnt = 0, m_acc = 0;
  bit m_low = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cfg(input int a, input int v);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 2'(a); cfg_wdata = 16'(v);
    @(negedge clk);
    cfg_we = 0;
    case (a)
      0: m_thr_hi = v;
      1: m_thr_lo = v;
      2: m_hold = v;
      default: m_settle = v;
    endcase
  endtask

  // driver: applies one sample, updates the reference model, queues expected results
  task automatic send(input int s, input int gap = 0);
    int mag, norm, hold;
    bit taken_hi, masked, change;
    @(negedge clk);
    smp_valid = 1; smp_data = 16'(s);
    mag = (s < 0) ? -s : s;
    taken_hi = (m_gain != 0);
    masked = (m_mask != 0);
    norm = masked ? m_last : (taken_hi ? s : s * 100);
    if (!masked) m_last = norm;
    if (masked) m_mask--;
    change = 0;
    hold = (m_hold == 0) ? 1 : m_hold;
    if (m_gain != 0 && mag > m_thr_hi) begin
      m_gain = 0; change = 1;
    end else if (m_gain == 0 && !masked) begin
      if (mag < m_thr_lo) begin
        m_below++;
        if (m_below >= hold) begin m_gain = 1; change = 1; end
      end else m_below = 0;
    end
    if (change) begin m_mask = m_settle; m_below = 0; end
    m_low = ((m_cnt == 0) ? 1'b0 : m_low) | !taken_hi;
    m_acc = ((m_cnt == 0) ? 0 : m_acc) + norm;
    if (m_cnt == 71) begin
      exp_sum_q.push_back(m_acc); exp_low_q.push_back(m_low); m_cnt = 0;
    end else m_cnt++;
    @(negedge clk);
    smp_valid = 0;
    // R2 R3: gain output follows the decision taken on this sample
    chk(gain_hi == m_gain[0], "R2/R3 gain select", gain_hi, m_gain);
    repeat (gap) @(negedge clk);
  endtask

  task automatic fill_block(input int v);
    while (m_cnt != 0) send(v);
  endtask

  // monitor: compares each finished block against the queue
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (exp_sum_q.size() == 0) chk(0, "R6 unexpected result strobe", 1, 0);
      else begin
        int es; bit el;
        es = exp_sum_q.pop_front(); el = exp_low_q.pop_front();
        chk($signed(res_sum) == es, "R4/R5/R6 block sum", $signed(res_sum), es);
        chk(res_lowgain == el, "R7 unity-gain flag", res_lowgain, el);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog expired", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(gain_hi == 0, "R1 gain after reset", gain_hi, 0);
    chk(res_valid == 0, "R1 strobe after reset", res_valid, 0);
    chk(ovr_flag == 0, "R1 overrange after reset", ovr_flag, 0);
    rst_n = 1;
    @(negedge clk);

    // R1 R3 R5: default hold of 72 quiet unity-gain samples, with idle gaps
    for (int i = 0; i < 72; i++) send((i % 2) ? 50 : -40, i % 3);
    chk(gain_hi == 1, "R3 up after default hold", gain_hi, 1);

    // R4: masked samples reuse the last value; R2: equal magnitude keeps gain
    for (int i = 0; i < 4; i++) send(7);
    send(21845);
    chk(gain_hi == 1, "R2 equal threshold keeps gain", gain_hi, 1);
    send(300); send(-200);
    send(-21846);
    chk(gain_hi == 0, "R2 drop above threshold", gain_hi, 0);
    for (int i = 0; i < 4; i++) send(25000);
    fill_block(90);

    // R9: new settings
    cfg(0, 1000); cfg(1, 10); cfg(2, 3); cfg(3, 2);
    while (m_gain == 0) send(5);
    send(3); send(3);
    fill_block(3);
    for (int i = 0; i < 71; i++) send((i % 2) ? 600 : -700);
    // drop on the last sample of a block
    send(1500);
    chk(gain_hi == 0, "R2 drop on block end", gain_hi, 0);
    @(negedge clk);
    // R3: run restarts after a loud sample
    send(5); send(5);
    send(5); send(5); send(20); send(5); send(5);
    chk(gain_hi == 0, "R3 run restarted", gain_hi, 0);
    send(5);
    chk(gain_hi == 1, "R3 up after three quiet", gain_hi, 1);
    fill_block(-4);

    // R8: sticky overrange
    send(32767);
    chk(ovr_flag == 1, "R8 set on positive full scale", ovr_flag, 1);
    @(negedge clk); ovr_clr = 1; @(negedge clk); ovr_clr = 0;
    chk(ovr_flag == 0, "R8 cleared", ovr_flag, 0);
    send(-32767);
    chk(ovr_flag == 0, "R8 not set below full scale", ovr_flag, 0);
    ovr_clr = 1;
    send(-32768);
    ovr_clr = 0;
    chk(ovr_flag == 1, "R8 set wins over clear", ovr_flag, 1);
    fill_block(2);

    repeat (4) @(negedge clk);
    chk(exp_sum_q.size() == 0, "R6 missing result strobes", exp_sum_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule